// File: doc/BRIEF.md
# Selectable-Ratio Third-Order Sinc Decimator

This block turns the single-bit output of a delta-sigma modulator into signed 16-bit samples. Each accepted bit is taken as +1 or -1 and passed through three cascaded running-sum integrators. A decimation counter then picks every N-th integrator value. Three differencing stages finish the sinc3 response, which is ((1 - z^-N)/(1 - z^-1))^3. The wide result is shifted down by the amount that suits the chosen ratio and clamped into 16-bit two's-complement.

A level input selects the ratio. Low gives N = 256 and high gives N = 128. Bits arrive on a strobe at one eighth of the master clock, so the output word rate is the master clock divided by 2048 or by 1024. Any change of the select level, like a reset, empties every integrator, differencing stage and counter. The filter then restarts from zero and withholds its first three results, because their window is only partly filled.

Top module: `cic3_decim`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `dec_vld` is 0 and `dec_word` is 0x0000.
- R2: A modulator bit of 1 counts as +1. A steady run of 1s gives positive full scale, 0x7FFF, which is the saturated value.
- R3: A modulator bit of 0 counts as -1. A steady run of 0s gives negative full scale, 0x8000.
- R4: A bitstream alternating 1,0 (zero mean) gives 0x0000 once the filter window is full.
- R5: With `rate_sel` = 0, one result comes out per 256 accepted bits. With `rate_sel` = 1, one result comes out per 128 accepted bits.
- R6: Each result is the sinc3 sum of the last 3N-2 mapped bits. It is shifted arithmetically right by 3*log2(N) - 15 (9 for N = 256, 6 for N = 128) and saturated to the range -32768..32767. A density of three 1s in every four bits gives 0x4000.
- R7: A bit is accepted only in a cycle where `smp_en` is 1. The value of `mod_bit` in any other cycle has no effect on the results.
- R8: A change of `rate_sel`, or a reset, clears all filter state. The first three results after the clear are suppressed, and no result comes out in the cycle after the change.
- R9: `dec_vld` is high for exactly one clock per result, and `dec_word` holds its value between results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | Bit-accept strobe, nominally one cycle in eight |
| mod_bit | input | 1 | Modulator output bit |
| rate_sel | input | 1 | Ratio select: 0 gives N=256, 1 gives N=128 |
| dec_word | output | 16 | Filtered sample, two's complement |
| dec_vld | output | 1 | One-cycle strobe marking a new `dec_word` |

## Verification
The hardest case to reach from the ports is the restart after a ratio change. In that case the suppression of three results, the cleared differencing history and the new shift amount all have to line up. Stopping at any one of them is not enough. The stimulus therefore switches `rate_sel` several times between long runs of bits, each run with a different density. After every switch the bench's own moving-sum model starts again from zero. The first results that are emitted then show whether the stale state was really flushed. Between strobes the bench keeps changing `mod_bit`, so a design that accepts bits outside the strobe would drift away from the model.

// File: rtl/cic3_pkg.sv
package cic3_pkg;
    localparam int OUT_W    = 16;
    localparam int LOG_N_LO = 7;
    localparam int LOG_N_HI = 8;
    localparam int ORDER    = 3;
    localparam int ACC_W    = ORDER * LOG_N_HI + 2;
    localparam int SKIP     = 3;
endpackage

// File: rtl/cic3_integ.sv
module cic3_integ #(
    parameter int ACC_W = 26,
    parameter int ORDER = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             smp_en,
    input  logic             mod_bit,
    output logic [ACC_W-1:0] acc_o
);
    typedef struct packed {
        logic [ORDER-1:0][ACC_W-1:0] s;
    } integ_st_t;

    integ_st_t st_d, st_q;

    always_comb begin
        logic [ACC_W-1:0] feed;
        st_d = st_q;
        feed = mod_bit ? ACC_W'(1) : {ACC_W{1'b1}};
        if (clr) begin
            st_d = '0;
        end else if (smp_en) begin
            for (int k = 0; k < ORDER; k++) begin
                st_d.s[k] = st_q.s[k] + feed;
                feed      = st_d.s[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_o = st_q.s[ORDER-1];

    // R7: with no strobe and no clear, the integrator output must not move
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_en && !clr) |=> $stable(acc_o));
    // R8: a clear empties the last integrator
    a_r8_integ_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_o == '0));
endmodule

// File: rtl/cic3_comb.sv
module cic3_comb #(
    parameter int ACC_W = 26,
    parameter int ORDER = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             take,
    input  logic [ACC_W-1:0] din,
    output logic [ACC_W-1:0] raw_o,
    output logic             raw_vld_o
);
    typedef struct packed {
        logic [ORDER-1:0][ACC_W-1:0] dly;
        logic [ACC_W-1:0]            raw;
        logic                        vld;
    } comb_st_t;

    comb_st_t st_d, st_q;

    always_comb begin
        logic [ACC_W-1:0] v;
        st_d     = st_q;
        st_d.vld = 1'b0;
        v        = din;
        if (clr) begin
            st_d = '0;
        end else if (take) begin
            for (int k = 0; k < ORDER; k++) begin
                st_d.dly[k] = v;
                v           = v - st_q.dly[k];
            end
            st_d.raw = v;
            st_d.vld = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_o     = st_q.raw;
    assign raw_vld_o = st_q.vld;

    // R9: the differencing stage never emits two results back to back
    a_r9_raw_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        raw_vld_o |=> !raw_vld_o);
    // R8: nothing is produced in the cycle after a clear
    a_r8_comb_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !raw_vld_o);
endmodule

// File: rtl/cic3_scale.sv
module cic3_scale #(
    parameter int ACC_W    = 26,
    parameter int OUT_W    = 16,
    parameter int LOG_N_LO = 7,
    parameter int LOG_N_HI = 8,
    parameter int ORDER    = 3
) (
    input  logic [ACC_W-1:0] raw,
    input  logic             rate_sel,
    output logic [OUT_W-1:0] word
);
    localparam int SH_LO = ORDER * LOG_N_LO - (OUT_W - 1);
    localparam int SH_HI = ORDER * LOG_N_HI - (OUT_W - 1);
    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);

    logic signed [ACC_W-1:0] shifted;

    always_comb begin
        shifted = rate_sel ? ($signed(raw) >>> SH_LO) : ($signed(raw) >>> SH_HI);
        if (shifted > MAXV)      word = MAXV[OUT_W-1:0];
        else if (shifted < MINV) word = MINV[OUT_W-1:0];
        else                     word = shifted[OUT_W-1:0];
    end
endmodule

// File: rtl/cic3_decim.sv
module cic3_decim
    import cic3_pkg::*;
#(
    parameter int P_OUT_W    = OUT_W,
    parameter int P_LOG_N_LO = LOG_N_LO,
    parameter int P_LOG_N_HI = LOG_N_HI
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_en,
    input  logic               mod_bit,
    input  logic               rate_sel,
    output logic [P_OUT_W-1:0] dec_word,
    output logic               dec_vld
);
    localparam int P_ACC_W = ORDER * P_LOG_N_HI + 2;
    localparam int CNT_W   = P_LOG_N_HI;
    localparam logic [CNT_W-1:0] LAST_HI = CNT_W'((2 ** P_LOG_N_HI) - 1);
    localparam logic [CNT_W-1:0] LAST_LO = CNT_W'((2 ** P_LOG_N_LO) - 1);
    localparam logic [1:0]       SKIP_V  = 2'(SKIP);

    typedef struct packed {
        logic               rate;
        logic [CNT_W-1:0]   cnt;
        logic               tick;
        logic [1:0]         warm;
        logic [P_OUT_W-1:0] word;
        logic               vld;
    } top_st_t;

    top_st_t st_d, st_q;
    logic               clr;
    logic [P_ACC_W-1:0] acc;
    logic [P_ACC_W-1:0] raw;
    logic               raw_vld;
    logic [P_OUT_W-1:0] scaled;

    assign clr = (rate_sel != st_q.rate);

    cic3_integ #(.ACC_W(P_ACC_W), .ORDER(ORDER)) u_integ (
        .clk(clk), .rst_n(rst_n), .clr(clr), .smp_en(smp_en),
        .mod_bit(mod_bit), .acc_o(acc)
    );

    cic3_comb #(.ACC_W(P_ACC_W), .ORDER(ORDER)) u_comb (
        .clk(clk), .rst_n(rst_n), .clr(clr), .take(st_q.tick),
        .din(acc), .raw_o(raw), .raw_vld_o(raw_vld)
    );

    cic3_scale #(.ACC_W(P_ACC_W), .OUT_W(P_OUT_W), .LOG_N_LO(P_LOG_N_LO),
                 .LOG_N_HI(P_LOG_N_HI), .ORDER(ORDER)) u_scale (
        .raw(raw), .rate_sel(st_q.rate), .word(scaled)
    );

    always_comb begin
        logic last;
        st_d      = st_q;
        st_d.rate = rate_sel;
        st_d.tick = 1'b0;
        st_d.vld  = 1'b0;
        last      = (st_q.cnt == (st_q.rate ? LAST_LO : LAST_HI));
        if (clr) begin
            st_d.cnt  = '0;
            st_d.warm = '0;
        end else begin
            if (smp_en) begin
                st_d.cnt  = last ? '0 : st_q.cnt + CNT_W'(1);
                st_d.tick = last;
            end
            if (raw_vld) begin
                if (st_q.warm == SKIP_V) begin
                    st_d.word = scaled;
                    st_d.vld  = 1'b1;
                end else begin
                    st_d.warm = st_q.warm + 2'd1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.rate <= rate_sel;
        end else begin
            st_q <= st_d;
        end
    end

    assign dec_word = st_q.word;
    assign dec_vld  = st_q.vld;

    // R9: the result strobe lasts one clock
    a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld |=> !dec_vld);
    // R9: the word only moves together with a strobe
    a_r9_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !st_d.vld |=> $stable(dec_word));
    // R8: a ratio change is never followed at once by a result
    a_r8_no_out_after_change: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel != st_q.rate) |=> !dec_vld);
    // R5: the decimation counter stays inside the selected ratio
    a_r5_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= (st_q.rate ? LAST_LO : LAST_HI));
endmodule

// File: tb/cic3_decim_bench.sv
module cic3_decim_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_en = 1'b0;
    logic        mod_bit = 1'b0;
    logic        rate_sel = 1'b0;
    logic [15:0] dec_word;
    logic        dec_vld;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cic3_decim u_cic3_decim (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .mod_bit(mod_bit),
        .rate_sel(rate_sel), .dec_word(dec_word), .dec_vld(dec_vld)
    );

    // independent moving-sum model: three cascaded boxcar sums of length N
    int xh [256];
    int y1h [256];
    int y2h [256];
    int y1, y2, y3;
    int nsmp;
    int log_n;
    int exp_q[$];
    string tag_q[$];
    string cur_tag;
    logic [15:0] lfsr = 16'hACE1;

    function automatic int scale_ref(int y, int lg);
        int v;
        v = y >>> (3 * lg - 15);
        if (v > 32767) v = 32767;
        if (v < -32768) v = -32768;
        return v;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < 256; i++) begin
            xh[i] = 0; y1h[i] = 0; y2h[i] = 0;
        end
        y1 = 0; y2 = 0; y3 = 0; nsmp = 0;
    endtask

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    // driver: one accepted bit, seven idle cycles with a scrambled mod_bit
    task automatic send_bit(logic b);
        int n, idx, x;
        n = 1 << log_n;
        @(negedge clk);
        smp_en = 1'b1;
        mod_bit = b;
        x = b ? 1 : -1;
        idx = nsmp % n;
        y1 = y1 + x - xh[idx];   xh[idx] = x;
        y2 = y2 + y1 - y1h[idx]; y1h[idx] = y1;
        y3 = y3 + y2 - y2h[idx]; y2h[idx] = y2;
        nsmp++;
        if ((nsmp % n) == 0 && (nsmp / n) >= 4) begin
            exp_q.push_back(scale_ref(y3, log_n));
            tag_q.push_back(cur_tag);
        end
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            smp_en = 1'b0;
            mod_bit = next_rand();   // R7: ignored bits between strobes
        end
    endtask

    task automatic drain(string req);
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
    endtask

    task automatic switch_rate(logic r);
        repeat (10) @(negedge clk);
        rate_sel = r;
        log_n = r ? 7 : 8;
        model_clear();
        @(negedge clk);
        check(dec_vld == 1'b0, "R8 quiet after change", dec_vld, 0);
    endtask

    // monitor: pops the scoreboard on every result strobe
    logic prev_vld = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (dec_vld && prev_vld)
                check(1'b0, "R9 strobe width", 2, 1);
            if (dec_vld) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8/R5 unexpected result", $signed(dec_word), 0);
                end else begin
                    int e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check($signed(dec_word) == e, t, $signed(dec_word), e);
                end
            end
        end
        prev_vld = dec_vld;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        log_n = 8;
        model_clear();
        repeat (4) @(negedge clk);
        // R1: reset state
        check(dec_vld == 1'b0, "R1 vld in reset", dec_vld, 0);
        check(dec_word == 16'h0000, "R1 word in reset", dec_word, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(dec_vld == 1'b0 && dec_word == 16'h0000, "R1 after release", dec_word, 0);

        // R2 and R5 (N=256): all ones saturate at 0x7FFF
        cur_tag = "R2 R5 ones N=256";
        for (int i = 0; i < 8 * 256; i++) send_bit(1'b1);
        drain("R5 count N=256");

        // R3 and R5 (N=128): all zeros give 0x8000
        switch_rate(1'b1);
        cur_tag = "R3 R5 zeros N=128";
        for (int i = 0; i < 8 * 128; i++) send_bit(1'b0);
        drain("R5 R8 count N=128");

        // R4: alternating bits give zero
        switch_rate(1'b0);
        cur_tag = "R4 R8 alternating N=256";
        for (int i = 0; i < 6 * 256; i++) send_bit(i[0] ? 1'b0 : 1'b1);
        drain("R8 count after change");

        // R6: density 3/4 gives 0x4000, then an irregular stream
        switch_rate(1'b1);
        cur_tag = "R6 density N=128";
        for (int i = 0; i < 7 * 128; i++) send_bit((i % 4) != 3);
        cur_tag = "R6 R7 random N=128";
        for (int i = 0; i < 10 * 128; i++) send_bit(next_rand() | next_rand());
        drain("R6 count");

        // R8: a reset in mid-run also clears and suppresses
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(dec_vld == 1'b0 && dec_word == 16'h0000, "R1 R8 mid-run reset", dec_word, 0);
        model_clear();
        rst_n = 1'b1;
        cur_tag = "R8 R6 after reset N=128";
        for (int i = 0; i < 6 * 128; i++) send_bit(next_rand());
        drain("R8 count after reset");

        // R6 at N=256 with an irregular stream
        switch_rate(1'b0);
        cur_tag = "R6 random N=256";
        for (int i = 0; i < 6 * 256; i++) send_bit(next_rand() & next_rand());
        drain("R6 count N=256");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule